// File: doc/BRIEF.md
# SPI Register Bank Target with Burst Auto-Increment

This block is an SPI target (mode 0) that gives an external host access to a bank of 128 eight-bit registers held in the core. A transaction begins when select goes low. The first byte is a command: a direction bit followed by a 7-bit start address. Data bytes follow the command. While select stays low, the address steps up by one after every completed data byte. A host can therefore read or write a run of consecutive registers with a single address phase. The address wraps from 127 back to 0.

The SPI pins are sampled on the system clock through two-flop synchronizers. SCK must stay high and stay low for at least three system clock cycles each. The core side has two plain ports. The write port is a one-cycle strobe that carries an address and a data byte. The read port is an address output, and the core answers it combinationally with the register contents. There is no valid/ready pair and no back-pressure toward the core: the core must take every write strobe on the cycle it is raised. The host paces all traffic through SCK.

Top module: `spi_regbank_slave`

## Requirements
- R1: The first bit shifted in after select falls selects the direction. A value of 1 makes the transaction a write and 0 makes it a read.
- R2: The command's remaining seven bits give the start address, sent MSB first (bit 6 first). Data bytes also travel MSB first, on both MOSI and MISO.
- R3: In a write transaction, each completed data byte raises `reg_wr_en` for exactly one system clock cycle. During that cycle `reg_wr_addr` and `reg_wr_data` carry the target address and the received byte.
- R4: While select stays low, the address increments by one after each completed data byte, for reads and writes alike. `reg_rd_addr` always shows the current address.
- R5: The address wraps from 127 to 0 within a burst.
- R6: In a read transaction, bit 7 of the addressed register is on MISO before the first rising SCK edge of each data byte. The next lower bit appears after each falling SCK edge.
- R7: MISO is driven low while select is high, during the command byte, and during every byte of a write transaction.
- R8: Select going high before a byte completes abandons that byte without any write strobe. The next transaction starts again with a command byte.
- R9: Out of reset, `reg_wr_en` and MISO are low and `reg_rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, low when not reading |
| reg_wr_en | output | 1 | One-cycle write strobe toward the register file |
| reg_wr_addr | output | 7 | Write address |
| reg_wr_data | output | 8 | Write data |
| reg_rd_addr | output | 7 | Current address for the combinational read port |
| reg_rd_data | input | 8 | Register contents at `reg_rd_addr` |

## Verification
The bound checker watches the write strobe on every cycle. It checks that the strobe is one cycle wide and carries known values, and that it never appears unless select was low. It also checks that back-to-back strobes in one burst carry addresses that step by one, with wrap. On every cycle it confirms that MISO stays low once select has been high for a few cycles. The bench scenarios cover the properties that depend on the content of the serial stream:
- bit order on both lines;
- read data against a reference copy of the registers, including the D7 setup before the first edge;
- low MISO during command and write bytes;
- the wrap in both directions;
- aborted bytes that leave the register file untouched.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } spi_phase_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [31:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL[WIDTH-1:0];
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL[WIDTH-1:0];
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,     // rising SCK seen
  input  logic              mosi,
  input  logic              shift_out,  // falling SCK seen, inside a byte
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] rx_byte,    // byte including the bit being sampled
  output logic              tx_msb
);
  logic [DATA_W-2:0] rx_q;
  logic [DATA_W-1:0] tx_q;

  assign rx_byte = {rx_q, mosi};
  assign tx_msb  = tx_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= '0;
    else if (sample) rx_q <= rx_byte[DATA_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_q <= '0;
    else if (load)      tx_q <= load_data;
    else if (shift_out) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,        // synchronized select, active high
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] rx_byte,
  output spi_phase_e        phase,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic              load,
  output logic              shift_out,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             byte_done;

  assign byte_done = sel && sck_rise && (bit_cnt == LAST_BIT);
  // no shift on the falling edge that closes a byte: the freshly loaded D7 must stay
  assign shift_out = sel && sck_fall && (bit_cnt != '0) && (phase == PH_DATA) && !is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      is_write <= 1'b0;
      addr     <= '0;
      load     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      load  <= 1'b0;
      if (!sel) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (byte_done) begin
          if (phase == PH_CMD) begin
            is_write <= rx_byte[DATA_W-1];
            addr     <= rx_byte[ADDR_W-1:0];
            phase    <= PH_DATA;
            load     <= !rx_byte[DATA_W-1];
          end else if (is_write) begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= rx_byte;
            addr    <= addr + 1'b1;
          end else begin
            addr <= addr + 1'b1;
            load <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pins_s;
  logic             sck_s, cs_n_s, mosi_s, sck_q, sel;
  logic             sck_rise, sck_fall;
  spi_phase_e       phase;
  logic             is_write, load, shift_out, tx_msb;
  logic [DATA_W-1:0] rx_byte;

  spi_rb_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(32'd2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_mosi, spi_cs_n, spi_sck}),
    .q(pins_s)
  );
  assign {mosi_s, cs_n_s, sck_s} = pins_s;
  assign sel = !cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end
  assign sck_rise = sck_s && !sck_q;
  assign sck_fall = !sck_s && sck_q;

  spi_rb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rx_byte(rx_byte),
    .phase(phase), .is_write(is_write), .addr(reg_rd_addr),
    .load(load), .shift_out(shift_out),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data)
  );

  spi_rb_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sample(sel && sck_rise), .mosi(mosi_s),
    .shift_out(shift_out), .load(load), .load_data(reg_rd_data),
    .rx_byte(rx_byte), .tx_msb(tx_msb)
  );

  assign spi_miso = (sel && phase == PH_DATA && !is_write) ? tx_msb : 1'b0;
endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data
);
  logic              seen_wr;
  logic [ADDR_W-1:0] last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr <= 1'b0;
      last_wr <= '0;
    end else if (spi_cs_n) begin
      seen_wr <= 1'b0;
    end else if (reg_wr_en) begin
      seen_wr <= 1'b1;
      last_wr <= reg_wr_addr;
    end
  end

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_wr_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !$isunknown({reg_wr_addr, reg_wr_data}));

  assert_wr_needs_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !$past(spi_cs_n, 3));

  assert_wr_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && seen_wr) |-> (reg_wr_addr == ADDR_W'(last_wr + 1'b1)));

  assert_miso_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
);

// File: tb/spi_regbank_slave_tb.sv
`timescale 1ns/1ps
module spi_regbank_slave_tb;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, mosi, miso, wr_en;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] core_mem [128];
  logic [7:0] ref_mem  [128];
  logic [14:0] exp_wr [$];
  logic [7:0]  wq [$];
  int errors = 0, checks = 0, wr_pulses = 0, exp_pulses = 0;

  always #2 clk = ~clk;

  spi_regbank_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .reg_rd_addr(rd_addr), .reg_rd_data(rd_data)
  );

  always @(posedge clk) if (wr_en) core_mem[wr_addr] <= wr_data;
  assign rd_data = core_mem[rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      wr_pulses++;
      if (exp_wr.size() == 0) chk(1'b0, "R8 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        logic [14:0] e;
        e = exp_wr.pop_front();
        chk(wr_addr == e[14:8], "R4 write address", wr_addr, e[14:8]);
        chk(wr_data == e[7:0], "R3 write data", wr_data, e[7:0]);
      end
    end
  end

  task automatic send_bit(input bit b, output bit so);
    mosi = b;
    #HALF;
    so = miso;
    sck = 1'b1;
    #HALF;
    sck = 1'b0;
  endtask

  // one frame; abort_bits >= 0 drops select after that many bits of the first data byte
  task automatic frame(input bit wr, input logic [6:0] a, input int nbytes, input int abort_bits);
    bit so, quiet;
    logic [7:0] cmd, got, d;
    logic [6:0] ad;
    cmd = {wr, a};
    ad = a;
    cs_n = 1'b0;
    quiet = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      send_bit(cmd[i], so);
      if (so) quiet = 1'b0;
    end
    chk(quiet, "R7 miso low in command", 1, 0);
    if (abort_bits >= 0) begin
      for (int i = 0; i < abort_bits; i++) send_bit(1'b1, so);
    end else begin
      for (int n = 0; n < nbytes; n++) begin
        if (wr) begin
          d = wq.pop_front();
          exp_wr.push_back({ad, d});
          ref_mem[ad] = d;
          exp_pulses++;
          quiet = 1'b1;
          for (int i = 7; i >= 0; i--) begin
            send_bit(d[i], so);
            if (so) quiet = 1'b0;
          end
          chk(quiet, "R7 miso low in write", 1, 0);
        end else begin
          for (int i = 7; i >= 0; i--) begin
            send_bit(1'b0, so);
            got[i] = so;
          end
          chk(got == ref_mem[ad], "R6 read data", got, ref_mem[ad]);
        end
        ad = ad + 1'b1;
      end
    end
    #HALF;
    cs_n = 1'b1;
    #(4*HALF);
    chk(miso == 1'b0, "R7 miso low while deselected", miso, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    #100 rst_n = 1'b1;
    #20;
    chk(wr_en == 1'b0, "R9 reset strobe", wr_en, 0);
    chk(miso == 1'b0, "R9 reset miso", miso, 0);
    chk(rd_addr == 7'd0, "R9 reset address", rd_addr, 0);
    #40;
    // R4: fill all registers in one burst
    for (int i = 0; i < 128; i++) wq.push_back(8'((i * 37 + 11) & 8'hFF));
    frame(1'b1, 7'd0, 128, -1);
    // R1/R2: single write then single read
    wq.push_back(8'hA5);
    frame(1'b1, 7'd5, 1, -1);
    frame(1'b0, 7'd5, 1, -1);
    chk(rd_addr == 7'd6, "R4 address after single read", rd_addr, 6);
    // R4: burst write and overlapping burst read
    wq.push_back(8'h01); wq.push_back(8'h80); wq.push_back(8'h3C); wq.push_back(8'hFF);
    frame(1'b1, 7'h20, 4, -1);
    frame(1'b0, 7'h1F, 6, -1);
    // R5: wrap in both directions
    wq.push_back(8'h5A); wq.push_back(8'hC3); wq.push_back(8'h00); wq.push_back(8'h96);
    frame(1'b1, 7'h7E, 4, -1);
    frame(1'b0, 7'h7F, 3, -1);
    chk(rd_addr == 7'd2, "R5 address after wrap", rd_addr, 2);
    // R8: aborted data byte, aborted command, then normal reads
    frame(1'b1, 7'h40, 0, 5);
    cs_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      bit so;
      send_bit(1'b1, so);
    end
    #HALF; cs_n = 1'b1; #(4*HALF);
    frame(1'b0, 7'h40, 2, -1);
    frame(1'b0, 7'd5, 1, -1);
    #400;
    chk(exp_wr.size() == 0, "R3 all expected writes seen", exp_wr.size(), 0);
    chk(wr_pulses == exp_pulses, "R8 write pulse count", wr_pulses, exp_pulses);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule